// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This unit holds the 16-bit stack pointer of a small processor core and produces the data-memory address for every stack access. The stack is full-descending. A byte push writes at the current pointer and then moves the pointer down by one. A byte pop first moves the pointer up by one and then reads at the new value. After reset the pointer holds the highest byte address of internal SRAM. That address is derived from two parameters, the SRAM base and the SRAM size.

Return addresses for calls and interrupts are saved as a multi-byte sequence. A call request stores `PC_BYTES` bytes on consecutive cycles, least significant byte first. A return request reads them back in the exact reverse order. While a sequence is running the unit reports busy. Software reaches the pointer through two 8-bit I/O write strobes, one for the low half and one for the high half. Each strobe changes only its own half. Every software write is checked against a lower floor, and a flag shows when the written value does not lie above that floor.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer equals SRAM_BASE + SRAM_BYTES - 1. With the defaults, base 0x2000 and size 0x2000, this is 0x3FFF. In the same state `busy` and `limit_err` are 0.
- R2: A push request while idle asserts `mem_we` in the same cycle with `mem_addr` equal to the pointer, and the pointer is one lower after the clock edge (modulo 2^16).
- R3: A pop request while idle asserts `mem_re` in the same cycle with `mem_addr` equal to the pointer plus one, and the pointer is one higher after the clock edge.
- R4: When the unit is idle, requests are served in the priority order push, pop, call, return, I/O write, and only the highest one present is served. In particular, a push and a pop in the same cycle act as a push alone.
- R5: A call request writes `PC_BYTES` bytes on consecutive cycles at addresses P, P-1, and so on, where P is the pointer. `mem_pc_acc` is 1 on each of these writes and `mem_pc_idx` counts 0, 1, and so on up to PC_BYTES-1. The pointer ends at P-PC_BYTES, and `busy` is 1 on every cycle of the sequence after the first.
- R6: A return request reads `PC_BYTES` bytes on consecutive cycles at addresses P+1, P+2, and so on. `mem_pc_acc` is 1 on each of these reads and `mem_pc_idx` counts down from PC_BYTES-1 to 0. The pointer ends at P+PC_BYTES.
- R7: While `busy` is 1, push, pop, call, return and I/O write requests are ignored. They produce no extra memory access and no pointer change.
- R8: An I/O low write loads `io_wdata` into bits 7:0 of the pointer and leaves bits 15:8 unchanged. An I/O high write loads bits 15:8 and leaves bits 7:0 unchanged. When both strobes are given in one cycle, both halves are loaded.
- R9: An I/O write in a cycle that serves a stack request is ignored.
- R10: After each served I/O write, `limit_err` is 1 if the resulting pointer is at or below STACK_FLOOR (default 0x2000) and 0 otherwise. It holds its value until the next served I/O write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Single-byte push request |
| pop_req | input | 1 | Single-byte pop request |
| call_req | input | 1 | Start saving a return address |
| ret_req | input | 1 | Start restoring a return address |
| io_lo_we | input | 1 | Software write strobe for pointer bits 7:0 |
| io_hi_we | input | 1 | Software write strobe for pointer bits 15:8 |
| io_wdata | input | 8 | Software write data |
| mem_addr | output | 16 | SRAM byte address of the current access |
| mem_we | output | 1 | SRAM write this cycle |
| mem_re | output | 1 | SRAM read this cycle |
| mem_pc_acc | output | 1 | The access carries a return-address byte |
| mem_pc_idx | output | 4 | Which return-address byte is accessed (0 = least significant) |
| busy | output | 1 | A return-address sequence is in progress |
| sp_val | output | 16 | Current pointer value, also the I/O read value of both halves |
| limit_err | output | 1 | The last software write left the pointer at or below the floor |

## Verification
The bench covers the following corner cases, and for each one names the wrong behaviour it would catch.
- Push and pop in the same cycle: a design that gets this wrong moves the pointer up, or not at all.
- Addressing on both sides of the pointer: a wrong post-decrement or pre-increment shows up as a memory address off by one.
- Byte order of a multi-byte return address: a reversed order shows up on `mem_pc_idx` during a call or a return.
- Requests arriving mid-sequence: a design that accepts them corrupts the pointer or adds stray accesses.
- Half writes through the I/O strobes: a wrong design would clobber the other half of the pointer.
- The floor boundary: values 0x2000 and 0x2001 separate an inclusive comparison from an exclusive one.
- Wraparound past 0x0000 and 0xFFFF.

// File: rtl/stkp_pkg.sv
package stkp_pkg;

    localparam int SP_W   = 16;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_CALL,
        OP_RET,
        OP_IO
    } op_e;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_DEC,
        STEP_INC
    } step_e;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_CALL,
        MODE_RET
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic [CNT_W-1:0]   cnt;
    } seq_t;

    function automatic logic below_floor(input logic [SP_W-1:0] val,
                                         input logic [SP_W-1:0] floor);
        return val <= floor;
    endfunction

endpackage

// File: rtl/stkp_arbiter.sv
module stkp_arbiter
    import stkp_pkg::*;
(
    input  logic busy,
    input  logic push_req,
    input  logic pop_req,
    input  logic call_req,
    input  logic ret_req,
    input  logic io_req,
    output op_e  op
);
    always_comb begin
        op = OP_NONE;
        if (!busy) begin
            if (push_req)      op = OP_PUSH;
            else if (pop_req)  op = OP_POP;
            else if (call_req) op = OP_CALL;
            else if (ret_req)  op = OP_RET;
            else if (io_req)   op = OP_IO;
        end
    end
endmodule

// File: rtl/stkp_seq.sv
module stkp_seq
    import stkp_pkg::*;
#(
    parameter int PC_BYTES = 2
)(
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    output step_e            step,
    output logic             pc_acc,
    output logic [CNT_W-1:0] pc_idx,
    output logic             busy
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PC_BYTES - 1);
    localparam bit MULTI = (PC_BYTES > 1);

    seq_t cur, nxt;

    always_comb begin
        step   = STEP_HOLD;
        pc_acc = 1'b0;
        pc_idx = '0;
        nxt    = cur;
        unique case (cur.mode)
            MODE_CALL: begin
                step   = STEP_DEC;
                pc_acc = 1'b1;
                pc_idx = cur.cnt;
                nxt.cnt = cur.cnt + 1'b1;
                if (cur.cnt == LAST) nxt = '{mode: MODE_IDLE, cnt: '0};
            end
            MODE_RET: begin
                step   = STEP_INC;
                pc_acc = 1'b1;
                pc_idx = LAST - cur.cnt;
                nxt.cnt = cur.cnt + 1'b1;
                if (cur.cnt == LAST) nxt = '{mode: MODE_IDLE, cnt: '0};
            end
            default: begin
                unique case (op)
                    OP_PUSH: step = STEP_DEC;
                    OP_POP:  step = STEP_INC;
                    OP_CALL: begin
                        step   = STEP_DEC;
                        pc_acc = 1'b1;
                        pc_idx = '0;
                        if (MULTI) nxt = '{mode: MODE_CALL, cnt: CNT_W'(1)};
                    end
                    OP_RET: begin
                        step   = STEP_INC;
                        pc_acc = 1'b1;
                        pc_idx = LAST;
                        if (MULTI) nxt = '{mode: MODE_RET, cnt: CNT_W'(1)};
                    end
                    default: step = STEP_HOLD;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '{mode: MODE_IDLE, cnt: '0};
        else     cur <= nxt;
    end

    assign busy = (cur.mode != MODE_IDLE);

    AST_SEQ_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cur.cnt != '0 && cur.cnt <= LAST)); // R5
    AST_SEQ_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (busy && cur.cnt != LAST) |=> (cur.mode == $past(cur.mode))); // R7
    AST_BUSY_IS_PC: assert property (@(posedge clk) disable iff (rst)
        busy |-> pc_acc); // R5

endmodule

// File: rtl/stkp_ptr_reg.sv
module stkp_ptr_reg
    import stkp_pkg::*;
#(
    parameter logic [SP_W-1:0] RESET_SP = 16'h3FFF,
    parameter logic [SP_W-1:0] FLOOR    = 16'h2000
)(
    input  logic              clk,
    input  logic              rst,
    input  step_e             step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [SP_W-1:0]   sp,
    output logic              lim_err
);
    logic [SP_W-1:0] sp_nxt;
    logic            io_any;

    assign io_any = wr_lo | wr_hi;

    always_comb begin
        unique case (step)
            STEP_DEC: sp_nxt = sp - 1'b1;
            STEP_INC: sp_nxt = sp + 1'b1;
            default:  sp_nxt = {wr_hi ? wdata : sp[SP_W-1:BYTE_W],
                                wr_lo ? wdata : sp[BYTE_W-1:0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp      <= RESET_SP;
            lim_err <= 1'b0;
        end else begin
            sp <= sp_nxt;
            if (io_any) lim_err <= below_floor(sp_nxt, FLOOR);
        end
    end

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_DEC) |=> (sp == $past(sp) - 1'b1)); // R2
    AST_POP_INC: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_INC) |=> (sp == $past(sp) + 1'b1)); // R3
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_HOLD && wr_lo && !wr_hi) |=> $stable(sp[SP_W-1:BYTE_W])); // R8
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_HOLD && wr_hi && !wr_lo) |=> $stable(sp[BYTE_W-1:0])); // R8
    AST_LIM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !io_any |=> $stable(lim_err)); // R10

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stkp_pkg::*;
#(
    parameter int SRAM_BASE   = 32'h2000,
    parameter int SRAM_BYTES  = 32'h2000,
    parameter int STACK_FLOOR = 32'h2000,
    parameter int PC_BYTES    = 2
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push_req,
    input  logic                 pop_req,
    input  logic                 call_req,
    input  logic                 ret_req,
    input  logic                 io_lo_we,
    input  logic                 io_hi_we,
    input  logic [7:0]           io_wdata,
    output logic [15:0]          mem_addr,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic                 mem_pc_acc,
    output logic [3:0]           mem_pc_idx,
    output logic                 busy,
    output logic [15:0]          sp_val,
    output logic                 limit_err
);
    localparam logic [SP_W-1:0] RESET_SP = SP_W'(SRAM_BASE + SRAM_BYTES - 1);
    localparam logic [SP_W-1:0] FLOOR_V  = SP_W'(STACK_FLOOR);

    op_e   op;
    step_e step;
    logic  wr_lo, wr_hi;

    stkp_arbiter u_arb (
        .busy     (busy),
        .push_req (push_req),
        .pop_req  (pop_req),
        .call_req (call_req),
        .ret_req  (ret_req),
        .io_req   (io_lo_we | io_hi_we),
        .op       (op)
    );

    stkp_seq #(.PC_BYTES(PC_BYTES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .step   (step),
        .pc_acc (mem_pc_acc),
        .pc_idx (mem_pc_idx),
        .busy   (busy)
    );

    assign wr_lo = (op == OP_IO) && io_lo_we;
    assign wr_hi = (op == OP_IO) && io_hi_we;

    stkp_ptr_reg #(.RESET_SP(RESET_SP), .FLOOR(FLOOR_V)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (io_wdata),
        .sp      (sp_val),
        .lim_err (limit_err)
    );

    assign mem_we   = (step == STEP_DEC);
    assign mem_re   = (step == STEP_INC);
    assign mem_addr = mem_re ? sp_val + 1'b1 : sp_val;

    AST_ACC_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_re})); // R4
    AST_PC_NEEDS_ACC: assert property (@(posedge clk) disable iff (rst)
        mem_pc_acc |-> (mem_we || mem_re)); // R5
    AST_BUSY_NO_IO: assert property (@(posedge clk) disable iff (rst)
        (busy && (io_lo_we || io_hi_we)) |-> (mem_we || mem_re)); // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_pc_acc |-> (int'(mem_pc_idx) < PC_BYTES)); // R6

endmodule

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_req = 0, pop_req = 0, call_req = 0, ret_req = 0;
    logic        io_lo_we = 0, io_hi_we = 0;
    logic [7:0]  io_wdata = '0;
    logic [15:0] mem_addr, sp_val;
    logic        mem_we, mem_re, mem_pc_acc, busy, limit_err;
    logic [3:0]  mem_pc_idx;

    int checks = 0;
    int fails  = 0;

    // bench model state
    logic [15:0] sp_m;
    int          mode_m;   // 0 idle, 1 call, 2 return
    int          cnt_m;
    logic        lim_m;

    always #4 clk = ~clk;

    stack_ptr_unit #(.PC_BYTES(N)) dut (
        .clk(clk), .rst(rst),
        .push_req(push_req), .pop_req(pop_req),
        .call_req(call_req), .ret_req(ret_req),
        .io_lo_we(io_lo_we), .io_hi_we(io_hi_we), .io_wdata(io_wdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_pc_acc(mem_pc_acc), .mem_pc_idx(mem_pc_idx),
        .busy(busy), .sp_val(sp_val), .limit_err(limit_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic floor_hit(input logic [15:0] v);
        return v <= 16'h2000;
    endfunction

    task automatic check_state(input string req);
        chk(sp_val == sp_m, req, 32'(sp_val), 32'(sp_m));
        chk(busy == (mode_m != 0), req, 32'(busy), 32'(mode_m != 0));
        chk(limit_err == lim_m, {req, "/R10"}, 32'(limit_err), 32'(lim_m));
    endtask

    // One clock: drive at negedge, check access, then advance the model.
    task automatic cyc(input bit p, q, c, r, lo, hi, input logic [7:0] d);
        logic        e_we, e_re, e_pc;
        logic [15:0] e_addr, nsp;
        int          e_idx;
        string       tag;
        @(negedge clk);
        push_req = p; pop_req = q; call_req = c; ret_req = r;
        io_lo_we = lo; io_hi_we = hi; io_wdata = d;
        #1;
        e_we = 0; e_re = 0; e_pc = 0; e_idx = 0; nsp = sp_m; tag = "R7";
        if (mode_m == 1) begin
            e_we = 1; e_pc = 1; e_idx = cnt_m; nsp = sp_m - 1;
            cnt_m++; if (cnt_m == N) mode_m = 0;
        end else if (mode_m == 2) begin
            e_re = 1; e_pc = 1; e_idx = N - 1 - cnt_m; nsp = sp_m + 1;
            cnt_m++; if (cnt_m == N) mode_m = 0;
        end else if (p) begin
            tag = q ? "R4" : "R2"; e_we = 1; nsp = sp_m - 1;
        end else if (q) begin
            tag = "R3"; e_re = 1; nsp = sp_m + 1;
        end else if (c) begin
            tag = "R5"; e_we = 1; e_pc = 1; e_idx = 0; nsp = sp_m - 1;
            mode_m = 1; cnt_m = 1;
        end else if (r) begin
            tag = "R6"; e_re = 1; e_pc = 1; e_idx = N - 1; nsp = sp_m + 1;
            mode_m = 2; cnt_m = 1;
        end else if (lo || hi) begin
            tag = "R8";
            nsp = {hi ? d : sp_m[15:8], lo ? d : sp_m[7:0]};
            lim_m = floor_hit(nsp);
        end
        if (mode_m != 0 && tag == "R7") tag = "R5";
        if (mode_m == 0 && tag == "R7" && e_pc) tag = "R6";
        if ((lo || hi) && (p || q || c || r)) tag = {tag, "/R9"};
        chk(mem_we == e_we, tag, 32'(mem_we), 32'(e_we));
        chk(mem_re == e_re, tag, 32'(mem_re), 32'(e_re));
        if (e_we || e_re) chk(mem_addr == (e_re ? sp_m + 16'd1 : sp_m), tag, 32'(mem_addr), 32'(e_re ? sp_m + 16'd1 : sp_m));
        chk(mem_pc_acc == e_pc, tag, 32'(mem_pc_acc), 32'(e_pc));
        if (e_pc) chk(int'(mem_pc_idx) == e_idx, tag, 32'(mem_pc_idx), 32'(e_idx));
        sp_m = nsp;
        @(posedge clk);
        #1;
        check_state(tag);
    endtask

    task automatic idle(); cyc(0,0,0,0,0,0,8'h00); endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        sp_m = 16'h3FFF; mode_m = 0; cnt_m = 0; lim_m = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        #1;
        // R1 reset state
        check_state("R1");
        // R2 push, R3 pop
        cyc(1,0,0,0,0,0,8'h00);
        cyc(0,1,0,0,0,0,8'h00);
        // R4 push and pop together, push over call
        cyc(1,1,0,0,0,0,8'h00);
        cyc(1,0,1,0,0,0,8'h00);
        // R5 call sequence, with requests thrown in while busy (R7)
        cyc(0,0,1,0,0,0,8'h00);
        cyc(1,1,1,1,1,1,8'h55);
        cyc(0,1,0,0,1,0,8'h00);
        idle();
        // R6 return sequence
        cyc(0,0,0,1,0,0,8'h00);
        cyc(1,0,0,0,0,1,8'h11);
        idle();
        // R8 half writes, R10 floor boundary
        cyc(0,0,0,0,0,1,8'h20);
        cyc(0,0,0,0,1,0,8'h00);   // 0x2000 -> flagged
        idle();
        cyc(0,0,0,0,1,0,8'h01);   // 0x2001 -> clear
        cyc(0,0,0,0,1,1,8'h1F);   // 0x1F1F -> flagged
        // R9 io write during a pop is ignored
        cyc(0,1,0,0,1,1,8'h77);
        // wraparound at 0x0000 and 0xFFFF
        cyc(0,0,0,0,1,1,8'h00);
        cyc(1,0,0,0,0,0,8'h00);
        cyc(0,1,0,0,0,0,8'h00);
        cyc(0,1,0,0,0,0,8'h00);
        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int w;
            w = $urandom_range(0, 99);
            cyc(w < 20, (w >= 15 && w < 40), (w >= 40 && w < 46), (w >= 46 && w < 52),
                (w >= 52 && w < 70) || (w >= 35 && w < 38), (w >= 62 && w < 80),
                8'($urandom_range(0, 255)));
        end
        repeat (N + 1) idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule